// File: doc/BRIEF.md
# Multiword DMA Strobe Sequencer

This block runs the device side of a parallel-disk multiword DMA handshake, one data word per strobe. The upstream bus master engine supplies a transfer enable, a direction and a stop request. The word buffer reports whether it can take or supply a word. Two programmable timing sets are provided, each an active count and a recovery count. The block answers the device's DMA request with an acknowledge. It then pulses the active-low read or write strobe once per word, and signals each completed word to the data path with a one-clock pulse.

The device request is looked at only on the clock edge where a strobe returns high. If the device has withdrawn its request at that edge, the acknowledge is released on the following clock. No further word is moved until the device requests again. By default DMA cycles use the same timing set as programmed I/O. A mode bit switches DMA cycles alone onto the fast set.

Top module: `mdma_strobe_seq`

## Requirements
- R1: While rst is high, and on the clock after it, dma_ack is 0, rd_n and wr_n are 1, and word_done is 0.
- R2: From idle, dma_ack rises on the clock after dev_req, xfer_en and buf_ready are all high with stop_req low. It never rises otherwise. The first strobe falls one clock after dma_ack rises.
- R3: xfer_dir is captured when dma_ack rises. 0 (device to memory) pulses rd_n and 1 (memory to device) pulses wr_n. The other strobe stays high, and the two are never low together.
- R4: Each strobe stays low for exactly the selected active count in clocks. A count of 0 acts as 1.
- R5: Within a burst, the strobe stays high between words for exactly the selected recovery count (0 acts as 1), provided buf_ready is high.
- R6: With fast_dma_only = 0, the DMA cycles use pio_act/pio_rec. With fast_dma_only = 1 they use fast_act/fast_rec.
- R7: dev_req is sampled on the clock edge where the strobe goes high. If it is low there, dma_ack falls on the next clock edge.
- R8: Changes of dev_req at any other time do not affect the burst. After dma_ack has been released, it stays low until dev_req is high again.
- R9: A stop_req pulse during a strobe lets that strobe finish its full active count. dma_ack then falls on the next clock even with dev_req high. A stop_req during recovery releases dma_ack on the next clock with no further strobe.
- R10: word_done is high for exactly the one clock that follows each strobe's return high.
- R11: If buf_ready is low when recovery expires, the strobe is held high and dma_ack held high until buf_ready returns. The next strobe then begins.
- R12: A strobe is low only while dma_ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_en | input | 1 | Bus master engine enables the transfer |
| xfer_dir | input | 1 | 0 device to memory (read strobe), 1 memory to device (write strobe) |
| stop_req | input | 1 | Engine request to end the burst cleanly |
| buf_ready | input | 1 | Word buffer can accept or supply a word |
| dev_req | input | 1 | Device DMA request, active high |
| pio_act | input | CNT_W | Active count of the programmed I/O timing set |
| pio_rec | input | CNT_W | Recovery count of the programmed I/O timing set |
| fast_act | input | CNT_W | Active count of the fast timing set |
| fast_rec | input | CNT_W | Recovery count of the fast timing set |
| fast_dma_only | input | 1 | Apply the fast set to DMA cycles |
| dma_ack | output | 1 | DMA acknowledge to the device, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| word_done | output | 1 | One-clock pulse per completed word |

## Verification
The bound checker watches several properties on every cycle: the reset values, mutual exclusion of the strobes, strobes only under acknowledge, acknowledge rising only on a full grant, the word-done pulse after each strobe rise, and the release after a low request at the sample edge. Pulse widths, recovery gaps, the choice of timing set, the direction actually used and the effect of stop, buffer stalls and request glitches depend on the programmed counts and on stimulus history. Only the bench's scenarios can show those, with a scoreboard that predicts each strobe pulse.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_ACT,
    ST_DROP,
    ST_REC
  } seq_state_t;

endpackage

// File: rtl/mdma_timing_sel.sv
module mdma_timing_sel #(
  parameter int CNT_W = 6
) (
  input  logic [CNT_W-1:0] pio_act,
  input  logic [CNT_W-1:0] pio_rec,
  input  logic [CNT_W-1:0] fast_act,
  input  logic [CNT_W-1:0] fast_rec,
  input  logic             fast_dma_only,
  output logic [CNT_W-1:0] act_ld,
  output logic [CNT_W-1:0] rec_ld
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] act_sel;
  logic [CNT_W-1:0] rec_sel;

  always_comb begin
    act_sel = fast_dma_only ? fast_act : pio_act;
    rec_sel = fast_dma_only ? fast_rec : pio_rec;
    // counter reload is length minus one; zero length behaves as one
    act_ld  = (act_sel == '0) ? '0 : act_sel - ONE;
    rec_ld  = (rec_sel == '0) ? '0 : rec_sel - ONE;
  end

endmodule

// File: rtl/mdma_phase_cnt.sv
module mdma_phase_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/mdma_ctrl.sv
module mdma_ctrl
  import mdma_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic xfer_en,
  input  logic xfer_dir,
  input  logic stop_req,
  input  logic buf_ready,
  input  logic dev_req,
  input  logic cnt_zero,
  output logic cnt_load,
  output logic cnt_use_rec,
  output logic cnt_dec,
  output logic dma_ack,
  output logic rd_n,
  output logic wr_n,
  output logic word_done
);

  seq_state_t st_q, st_d;
  logic ack_q, ack_d;
  logic dir_q, dir_d;
  logic rd_q, rd_d;
  logic wr_q, wr_d;
  logic done_q, done_d;
  logic stop_q, stop_d;
  logic stop_now;
  logic grant;

  assign grant    = dev_req && xfer_en && buf_ready && !stop_req;
  assign stop_now = stop_q || stop_req || !xfer_en;

  always_comb begin
    st_d        = st_q;
    ack_d       = ack_q;
    dir_d       = dir_q;
    rd_d        = rd_q;
    wr_d        = wr_q;
    done_d      = 1'b0;
    cnt_load    = 1'b0;
    cnt_use_rec = 1'b0;
    cnt_dec     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (grant) begin
          ack_d = 1'b1;
          dir_d = xfer_dir;
          st_d  = ST_LEAD;
        end
      end
      ST_LEAD: begin
        if (stop_now) begin
          ack_d = 1'b0;
          st_d  = ST_IDLE;
        end else begin
          rd_d     = dir_q;
          wr_d     = !dir_q;
          cnt_load = 1'b1;
          st_d     = ST_ACT;
        end
      end
      ST_ACT: begin
        if (cnt_zero) begin
          rd_d   = 1'b1;
          wr_d   = 1'b1;
          done_d = 1'b1;
          // request is looked at on the very edge the strobe rises
          if (!dev_req || stop_now) begin
            st_d = ST_DROP;
          end else begin
            cnt_load    = 1'b1;
            cnt_use_rec = 1'b1;
            st_d        = ST_REC;
          end
        end else begin
          cnt_dec = 1'b1;
        end
      end
      ST_DROP: begin
        ack_d = 1'b0;
        st_d  = ST_IDLE;
      end
      ST_REC: begin
        if (stop_now) begin
          ack_d = 1'b0;
          st_d  = ST_IDLE;
        end else if (!cnt_zero) begin
          cnt_dec = 1'b1;
        end else if (buf_ready) begin
          rd_d     = dir_q;
          wr_d     = !dir_q;
          cnt_load = 1'b1;
          st_d     = ST_ACT;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        ack_d = 1'b0;
        rd_d  = 1'b1;
        wr_d  = 1'b1;
      end
    endcase
    stop_d = (st_d != ST_IDLE) && (stop_q || stop_req);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      ack_q  <= 1'b0;
      dir_q  <= 1'b0;
      rd_q   <= 1'b1;
      wr_q   <= 1'b1;
      done_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ack_q  <= ack_d;
      dir_q  <= dir_d;
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      done_q <= done_d;
      stop_q <= stop_d;
    end
  end

  assign dma_ack   = ack_q;
  assign rd_n      = rd_q;
  assign wr_n      = wr_q;
  assign word_done = done_q;

endmodule

// File: rtl/mdma_strobe_seq.sv
module mdma_strobe_seq #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_en,
  input  logic             xfer_dir,
  input  logic             stop_req,
  input  logic             buf_ready,
  input  logic             dev_req,
  input  logic [CNT_W-1:0] pio_act,
  input  logic [CNT_W-1:0] pio_rec,
  input  logic [CNT_W-1:0] fast_act,
  input  logic [CNT_W-1:0] fast_rec,
  input  logic             fast_dma_only,
  output logic             dma_ack,
  output logic             rd_n,
  output logic             wr_n,
  output logic             word_done
);

  logic [CNT_W-1:0] act_ld;
  logic [CNT_W-1:0] rec_ld;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_load;
  logic             cnt_use_rec;
  logic             cnt_dec;
  logic             cnt_zero;

  mdma_timing_sel #(.CNT_W(CNT_W)) u_tsel (
    .pio_act       (pio_act),
    .pio_rec       (pio_rec),
    .fast_act      (fast_act),
    .fast_rec      (fast_rec),
    .fast_dma_only (fast_dma_only),
    .act_ld        (act_ld),
    .rec_ld        (rec_ld)
  );

  assign cnt_val = cnt_use_rec ? rec_ld : act_ld;

  mdma_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .dec      (cnt_dec),
    .zero     (cnt_zero)
  );

  mdma_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .xfer_en     (xfer_en),
    .xfer_dir    (xfer_dir),
    .stop_req    (stop_req),
    .buf_ready   (buf_ready),
    .dev_req     (dev_req),
    .cnt_zero    (cnt_zero),
    .cnt_load    (cnt_load),
    .cnt_use_rec (cnt_use_rec),
    .cnt_dec     (cnt_dec),
    .dma_ack     (dma_ack),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .word_done   (word_done)
  );

endmodule

// File: rtl/mdma_strobe_seq_chk.sv
module mdma_strobe_seq_chk (
  input logic clk,
  input logic rst,
  input logic xfer_en,
  input logic buf_ready,
  input logic dev_req,
  input logic dma_ack,
  input logic rd_n,
  input logic wr_n,
  input logic word_done
);

  logic strb_hi;
  assign strb_hi = rd_n && wr_n;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!dma_ack && rd_n && wr_n && !word_done));

  // R2
  ack_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_ack) |-> $past(dev_req && xfer_en && buf_ready));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  // R7
  req_release_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(strb_hi) && !$past(dev_req)) |=> !dma_ack);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(strb_hi) |-> word_done);

  // R12
  strobe_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !strb_hi |-> dma_ack);

endmodule

bind mdma_strobe_seq mdma_strobe_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .xfer_en   (xfer_en),
  .buf_ready (buf_ready),
  .dev_req   (dev_req),
  .dma_ack   (dma_ack),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .word_done (word_done)
);

// File: tb/mdma_strobe_seq_test.sv
module mdma_strobe_seq_test;

  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          xfer_en = 1'b0;
  logic          xfer_dir = 1'b0;
  logic          stop_req = 1'b0;
  logic          buf_ready = 1'b0;
  logic          dev_req = 1'b0;
  logic [CW-1:0] pio_act = '0;
  logic [CW-1:0] pio_rec = '0;
  logic [CW-1:0] fast_act = '0;
  logic [CW-1:0] fast_rec = '0;
  logic          fast_dma_only = 1'b0;
  logic          dma_ack;
  logic          rd_n;
  logic          wr_n;
  logic          word_done;

  always #2.5 clk = ~clk;

  mdma_strobe_seq #(.CNT_W(CW)) uut (
    .clk (clk), .rst (rst), .xfer_en (xfer_en), .xfer_dir (xfer_dir),
    .stop_req (stop_req), .buf_ready (buf_ready), .dev_req (dev_req),
    .pio_act (pio_act), .pio_rec (pio_rec), .fast_act (fast_act),
    .fast_rec (fast_rec), .fast_dma_only (fast_dma_only),
    .dma_ack (dma_ack), .rd_n (rd_n), .wr_n (wr_n), .word_done (word_done)
  );

  typedef struct {
    bit wr;
    int width;
    int gap;
  } pulse_t;

  pulse_t exp_q[$];
  int errors = 0;
  int checks = 0;
  bit mon_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input int got, input int want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, want, $time);
    end
  endtask

  function automatic bit strobe_low();
    return !(rd_n && wr_n);
  endfunction

  // scoreboard monitor: measures every strobe pulse against the queue
  int  low_cnt = 0;
  int  hi_cnt = 0;
  bit  prev_low = 1'b0;
  bit  saw_wr = 1'b0;
  bit  saw_rd = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (strobe_low()) begin
        if (!prev_low) begin
          low_cnt = 0;
          saw_wr = 1'b0;
          saw_rd = 1'b0;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R8 unexpected strobe", 1, 0);
          end else if (exp_q[0].gap >= 0) begin
            chk(hi_cnt == exp_q[0].gap, "R5 recovery gap", hi_cnt, exp_q[0].gap);
          end
        end
        low_cnt++;
        if (!wr_n) saw_wr = 1'b1;
        if (!rd_n) saw_rd = 1'b1;
        chk(!(!rd_n && !wr_n), "R3 both strobes low", 1, 0);
      end else begin
        if (prev_low) begin
          hi_cnt = 1;
          if (exp_q.size() != 0) begin
            pulse_t e;
            e = exp_q.pop_front();
            chk(low_cnt == e.width, "R4 active width", low_cnt, e.width);
            chk(saw_wr == e.wr && saw_rd == !e.wr, "R3 strobe choice", int'(saw_wr), int'(e.wr));
            chk(word_done == 1'b1, "R10 word_done after rise", int'(word_done), 1);
          end
        end else begin
          hi_cnt++;
        end
      end
      prev_low = strobe_low();
    end
  end

  task automatic wait_low();
    do @(negedge clk); while (!strobe_low());
  endtask

  task automatic wait_high();
    do @(negedge clk); while (strobe_low());
  endtask

  task automatic set_timing(input int pa, input int pr, input int fa, input int fr, input bit fo);
    pio_act = CW'(pa);
    pio_rec = CW'(pr);
    fast_act = CW'(fa);
    fast_rec = CW'(fr);
    fast_dma_only = fo;
  endtask

  // driver: pushes the expected pulses, runs a burst of n words, ends it by
  // dropping dev_req during the last strobe
  task automatic burst(input int n, input bit dir, input int w, input int g, input bit glitch);
    for (int i = 0; i < n; i++) begin
      pulse_t p;
      p.wr = dir;
      p.width = w;
      p.gap = (i == 0) ? -1 : g;
      exp_q.push_back(p);
    end
    xfer_dir = dir;
    xfer_en = 1'b1;
    buf_ready = 1'b1;
    dev_req = 1'b1;
    @(negedge clk);
    chk(dma_ack == 1'b1, "R2 ack after grant", int'(dma_ack), 1);
    chk(rd_n && wr_n, "R2 one ack clock before strobe", int'(rd_n && wr_n), 1);
    for (int i = 0; i < n; i++) begin
      wait_low();
      if (i == n - 1) dev_req = 1'b0;
      wait_high();
      if (glitch && i == 0) begin
        dev_req = 1'b0;
        @(negedge clk);
        dev_req = 1'b1;
      end
    end
    chk(dma_ack == 1'b1, "R7 ack held through sample clock", int'(dma_ack), 1);
    @(negedge clk);
    chk(dma_ack == 1'b0, "R7 ack released next clock", int'(dma_ack), 0);
    @(negedge clk);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    chk(dma_ack == 1'b0, "R1 reset ack", int'(dma_ack), 0);
    chk(rd_n && wr_n, "R1 reset strobes", int'(rd_n && wr_n), 1);
    chk(word_done == 1'b0, "R1 reset word_done", int'(word_done), 0);
    rst = 1'b0;
    mon_on = 1'b1;
    set_timing(3, 2, 1, 1, 1'b0);

    // R2: incomplete grant conditions keep ack low
    dev_req = 1'b1; xfer_en = 1'b1; buf_ready = 1'b0;
    repeat (6) @(negedge clk);
    chk(dma_ack == 1'b0, "R2 no ack without buf_ready", int'(dma_ack), 0);
    buf_ready = 1'b1; xfer_en = 1'b0;
    repeat (6) @(negedge clk);
    chk(dma_ack == 1'b0, "R2 no ack without xfer_en", int'(dma_ack), 0);
    dev_req = 1'b0;
    @(negedge clk);

    // R3 R4 R5 R6 R7 R10: read burst on the programmed I/O set
    burst(3, 1'b0, 3, 2, 1'b0);
    // R6: fast set for DMA only, write direction
    set_timing(4, 3, 1, 1, 1'b1);
    burst(2, 1'b1, 1, 1, 1'b0);
    // R6: option clear, fast set ignored
    set_timing(2, 3, 1, 1, 1'b0);
    burst(2, 1'b0, 2, 3, 1'b0);
    // R4 R5: zero counts act as one
    set_timing(0, 0, 5, 5, 1'b0);
    burst(3, 1'b1, 1, 1, 1'b0);
    // R8: request glitch during recovery has no effect
    set_timing(2, 4, 1, 1, 1'b0);
    burst(3, 1'b0, 2, 4, 1'b1);

    // R8: no restart while request stays low
    repeat (10) @(negedge clk);
    chk(dma_ack == 1'b0, "R8 no ack while dev_req low", int'(dma_ack), 0);

    // R9: stop during a strobe completes the full width
    set_timing(5, 2, 1, 1, 1'b0);
    exp_q.push_back('{wr: 1'b1, width: 5, gap: -1});
    xfer_dir = 1'b1;
    dev_req = 1'b1;
    wait_low();
    @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    wait_high();
    dev_req = 1'b0;
    chk(dma_ack == 1'b1, "R9 ack held one clock after stopped strobe", int'(dma_ack), 1);
    @(negedge clk);
    chk(dma_ack == 1'b0, "R9 ack released after stop", int'(dma_ack), 0);
    @(negedge clk);

    // R11: buffer stall stretches recovery
    set_timing(2, 1, 1, 1, 1'b0);
    exp_q.push_back('{wr: 1'b0, width: 2, gap: -1});
    exp_q.push_back('{wr: 1'b0, width: 2, gap: -1});
    xfer_dir = 1'b0;
    dev_req = 1'b1;
    wait_low();
    buf_ready = 1'b0;
    wait_high();
    repeat (6) @(negedge clk);
    chk(rd_n && wr_n, "R11 strobe held high during stall", int'(rd_n && wr_n), 1);
    chk(dma_ack == 1'b1, "R11 ack held during stall", int'(dma_ack), 1);
    buf_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!rd_n, "R11 next strobe after buffer ready", int'(rd_n), 0);
    dev_req = 1'b0;
    wait_high();
    @(negedge clk);
    chk(dma_ack == 1'b0, "R7 release after stalled burst", int'(dma_ack), 0);

    // R9: stop during recovery, no further strobe
    set_timing(1, 6, 1, 1, 1'b0);
    exp_q.push_back('{wr: 1'b1, width: 1, gap: -1});
    xfer_dir = 1'b1;
    dev_req = 1'b1;
    wait_low();
    wait_high();
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    dev_req = 1'b0;
    chk(dma_ack == 1'b0, "R9 stop in recovery releases ack", int'(dma_ack), 0);
    repeat (8) @(negedge clk);
    chk(rd_n && wr_n, "R9 no strobe after stop", int'(rd_n && wr_n), 1);

    chk(exp_q.size() == 0, "R4 all expected pulses seen", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule